// File: doc/BRIEF.md
# Synchronous Serial Status Flag Register

This block holds the interrupt status flags of a synchronous serial unit: overrun error, transmit done, transmit buffer empty, receive buffer full and conflict error. The transmit and receive datapaths raise the flags with one-cycle event strobes. Software reads the flags over a simple register bus. It clears a flag by writing 0 to that bit, and the write only takes effect if the flag was read as 1 since the last write. Writes to the transmit data register and reads of the receive data register also clear the flags they concern, with no write to the status register.

The block also decides whether an offered receive frame may enter the receive data register. If the receive buffer is still full, the frame causes an overrun instead. A two-state halt machine drives the stop request to the serial engine. In state RUN the engine may shift. RUN goes to HALT on an overrun trip. HALT goes back to RUN when the overrun flag is cleared and no new trip arrives in the same cycle. An interrupt request is the OR of every flag masked by its enable bit.

Top module: `serial_status_flags`

## Requirements
- R1: After reset the status reads 0x04: transmit empty (bit 2) is 1 and every other bit is 0. Halt and irq are 0.
- R2: Bits 7, 5 and 4 of the status always read 0, and writing 1 to them has no effect.
- R3: A status write clears bit n (6 overrun, 3 transmit done, 2 transmit empty, 1 receive full, 0 conflict) when bit n of the written data is 0 and a status read after the previous write returned bit n as 1. A write of 0 without such a read leaves the flag unchanged. Each write consumes the read.
- R4: When a set event and a clearing write reach a flag in the same cycle, the flag stays 1.
- R5: An offered frame (rx_offer) is stored, which means rx_store=1 in that cycle, when the receive full flag is 0 and the block is not halted. Receive full then reads 1 on the next cycle. A receive data register read (rdata_rd) clears it.
- R6: An offered frame while receive full is 1 sets overrun (bit 6) on the next cycle. It is not stored, and receive full stays 1.
- R7: halt equals the overrun flag on every cycle. While halted, an offered frame is not stored and changes no flag.
- R8: Transmit empty reads 1 on the cycle after tx_en was 0 or tx_load_evt was 1. It clears on a transmit data write with tx_en=1. A transmit data write with tx_en=0 leaves it 1.
- R9: Transmit done (bit 3) sets on tx_last_evt while transmit empty is 1, and stays 0 if transmit empty is 0. A transmit data write clears it.
- R10: clash_evt sets the conflict flag (bit 0) on the next cycle.
- R11: irq is 1 exactly when some status bit and the irq_en bit at the same position are both 1, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable level |
| irq_en | input | REG_W | Per-bit interrupt enables aligned with status bits |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | REG_W | Status write data |
| stat_rdata | output | REG_W | Current status value |
| tdata_wr | input | 1 | Transmit data register written |
| rdata_rd | input | 1 | Receive data register read |
| tx_load_evt | input | 1 | Buffered data moved into the transmit shifter |
| tx_last_evt | input | 1 | Last bit of a frame shifted out |
| rx_offer | input | 1 | Received frame ready to enter the receive data register |
| clash_evt | input | 1 | Conflict error detected |
| rx_store | output | 1 | Offered frame accepted into the receive data register |
| halt | output | 1 | Stop request to the serial engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with REG_W=8, so the bus width matches the fixed flag positions and the three reserved bits can be probed with ones. A behavioural model compares the status, halt, rx_store and irq on every cycle. Directed sequences cover the following cases:
- a clearing write without a prior read, and a second write after one that already consumed the read;
- a set colliding with a clear;
- an overrun followed by a frame offered while halted;
- transmit data writes with the enable both high and low.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
    localparam int NFLAG = 5;
    localparam int IX_CLASH  = 0;
    localparam int IX_RXFULL = 1;
    localparam int IX_TXEMP  = 2;
    localparam int IX_TXDONE = 3;
    localparam int IX_OVR    = 4;

    localparam int FLAG_POS [NFLAG] = '{0, 1, 2, 3, 6};
    localparam logic [NFLAG-1:0] FLAG_RST = 5'b00100;

    typedef enum logic {
        HS_RUN  = 1'b0,
        HS_HALT = 1'b1
    } halt_state_e;
endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic auto_clr,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic wr_bit,
    output logic q,
    output logic clr_fire
);
    logic armed;
    logic hs_clr;

    always_comb begin
        hs_clr   = stat_wr & armed & ~wr_bit;
        clr_fire = q & ~set_evt & (hs_clr | auto_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= RST_VAL;
            armed <= 1'b0;
        end else begin
            if (set_evt)
                q <= 1'b1;
            else if (hs_clr || auto_clr)
                q <= 1'b0;
            if (stat_rd)
                armed <= q;
            else if (stat_wr)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/ssf_halt_fsm.sv
module ssf_halt_fsm
    import ssf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_offer,
    input  logic rx_full,
    input  logic ovr_release,
    output logic ovr_trip,
    output logic rx_accept,
    output logic halt
);
    halt_state_e state, state_nx;

    always_comb begin
        ovr_trip = rx_offer & rx_full;
        state_nx = state;
        unique case (state)
            HS_RUN:  if (ovr_trip) state_nx = HS_HALT;
            HS_HALT: if (ovr_release && !ovr_trip) state_nx = HS_RUN;
            default: state_nx = HS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HS_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        halt      = (state == HS_HALT);
        rx_accept = rx_offer & ~rx_full & (state == HS_RUN);
    end
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
    import ssf_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [REG_W-1:0] irq_en,
    input  logic             stat_rd,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] stat_wdata,
    output logic [REG_W-1:0] stat_rdata,
    input  logic             tdata_wr,
    input  logic             rdata_rd,
    input  logic             tx_load_evt,
    input  logic             tx_last_evt,
    input  logic             rx_offer,
    input  logic             clash_evt,
    output logic             rx_store,
    output logic             halt,
    output logic             irq
);
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] aclr_vec;
    logic [NFLAG-1:0] fire_vec;
    logic [NFLAG-1:0] wbit_vec;
    logic [REG_W-1:0] status;
    logic             ovr_trip;
    logic             rx_accept;
    logic             unused_sink;

    ssf_halt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_offer    (rx_offer),
        .rx_full     (flag_q[IX_RXFULL]),
        .ovr_release (fire_vec[IX_OVR]),
        .ovr_trip    (ovr_trip),
        .rx_accept   (rx_accept),
        .halt        (halt)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[IX_CLASH]   = clash_evt;
        set_vec[IX_RXFULL]  = rx_accept;
        set_vec[IX_TXEMP]   = ~tx_en | tx_load_evt;
        set_vec[IX_TXDONE]  = tx_last_evt & flag_q[IX_TXEMP];
        set_vec[IX_OVR]     = ovr_trip;

        aclr_vec            = '0;
        aclr_vec[IX_RXFULL] = rdata_rd;
        aclr_vec[IX_TXEMP]  = tdata_wr & tx_en;
        aclr_vec[IX_TXDONE] = tdata_wr;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign wbit_vec[i] = stat_wdata[FLAG_POS[i]];
        ssf_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_evt  (set_vec[i]),
            .auto_clr (aclr_vec[i]),
            .stat_rd  (stat_rd),
            .stat_wr  (stat_wr),
            .wr_bit   (wbit_vec[i]),
            .q        (flag_q[i]),
            .clr_fire (fire_vec[i])
        );
    end

    always_comb begin
        status = '0;
        for (int i = 0; i < NFLAG; i++)
            status[FLAG_POS[i]] = flag_q[i];
    end

    assign stat_rdata  = status;
    assign rx_store    = rx_accept;
    assign irq         = |(status & irq_en);
    assign unused_sink = ^{stat_wdata, fire_vec[IX_OVR-1:0]};
endmodule

// File: rtl/serial_status_flags_chk.sv
module serial_status_flags_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic [REG_W-1:0] stat_rdata,
    input logic             tx_last_evt,
    input logic             rx_offer,
    input logic             clash_evt,
    input logic             rx_store,
    input logic             halt
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[7] == 1'b0) && (stat_rdata[5] == 1'b0) && (stat_rdata[4] == 1'b0));

    a_r5_store_fills: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |=> stat_rdata[1]);

    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_offer && stat_rdata[1]) |=> stat_rdata[6]);

    a_r6_overrun_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_offer && stat_rdata[1]) |-> !rx_store);

    a_r7_halt_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        halt == stat_rdata[6]);

    a_r7_no_store_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !rx_store);

    a_r8_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> stat_rdata[2]);

    a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_last_evt && stat_rdata[2]) |=> stat_rdata[3]);

    a_r10_clash_sets: assert property (@(posedge clk) disable iff (!rst_n)
        clash_evt |=> stat_rdata[0]);
endmodule

bind serial_status_flags serial_status_flags_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/serial_status_flags_tb.sv
module serial_status_flags_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_en = 1'b1;
    logic [W-1:0] irq_en = '0;
    logic         stat_rd = 1'b0, stat_wr = 1'b0;
    logic [W-1:0] stat_wdata = '0;
    logic [W-1:0] stat_rdata;
    logic         tdata_wr = 1'b0, rdata_rd = 1'b0;
    logic         tx_load_evt = 1'b0, tx_last_evt = 1'b0;
    logic         rx_offer = 1'b0, clash_evt = 1'b0;
    logic         rx_store, halt, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serial_status_flags #(.REG_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .tdata_wr(tdata_wr), .rdata_rd(rdata_rd),
        .tx_load_evt(tx_load_evt), .tx_last_evt(tx_last_evt),
        .rx_offer(rx_offer), .clash_evt(clash_evt),
        .rx_store(rx_store), .halt(halt), .irq(irq)
    );

    function automatic void check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // behavioural reference model
    bit [7:0] m_st = 8'h04;
    bit [7:0] m_rd1 = 8'h00;

    function automatic bit model_store();
        return rx_offer && !m_st[1] && !m_st[6];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st  = 8'h04;
            m_rd1 = 8'h00;
        end else begin
            bit [7:0] nxt;
            bit [7:0] seen;
            nxt  = m_st;
            seen = m_rd1;
            if (stat_wr) begin
                for (int b = 0; b < 8; b++)
                    if (seen[b] && !stat_wdata[b]) nxt[b] = 1'b0;
                m_rd1 = 8'h00;
            end
            if (stat_rd) m_rd1 = m_st;
            if (tdata_wr) nxt[3] = 1'b0;
            if (tdata_wr && tx_en) nxt[2] = 1'b0;
            if (rdata_rd) nxt[1] = 1'b0;
            if (clash_evt) nxt[0] = 1'b1;
            if (!tx_en || tx_load_evt) nxt[2] = 1'b1;
            if (tx_last_evt && m_st[2]) nxt[3] = 1'b1;
            if (rx_offer && m_st[1]) nxt[6] = 1'b1;
            if (model_store()) nxt[1] = 1'b1;
            m_st = nxt & 8'h4F;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 status vs model", stat_rdata, m_st);
            check("R7 halt vs model", halt, m_st[6]);
            check("R5 rx_store vs model", rx_store, model_store());
            check("R11 irq vs model", irq, |(m_st & irq_en));
        end
    end

    task automatic idle();
        stat_rd = 0; stat_wr = 0; stat_wdata = '0; tdata_wr = 0; rdata_rd = 0;
        tx_load_evt = 0; tx_last_evt = 0; rx_offer = 0; clash_evt = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        idle();
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 reset status", stat_rdata, 8'h04);
        check("R1 reset halt", halt, 0);
        check("R1 reset irq", irq, 0);

        // R2 reserved bits ignore ones
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 8'hFF; tick();
        check("R2 reserved stay zero", stat_rdata, 8'h04);

        // R8 transmit data write clears empty
        tdata_wr = 1; tick();
        check("R8 empty cleared by write", stat_rdata, 8'h00);
        // R9 last bit with empty 0 does nothing
        tx_last_evt = 1; tick();
        check("R9 no done while not empty", stat_rdata, 8'h00);
        tx_load_evt = 1; tick();
        check("R8 load sets empty", stat_rdata, 8'h04);
        tx_last_evt = 1; tick();
        check("R9 done sets", stat_rdata, 8'h0C);

        // R3 handshake
        stat_wr = 1; stat_wdata = 8'h00; tick();
        check("R3 blind write ignored", stat_rdata, 8'h0C);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 8'hF7; tick();
        check("R3 clear done only", stat_rdata, 8'h04);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 8'hFF; tick();
        stat_wr = 1; stat_wdata = 8'h00; tick();
        check("R3 read consumed by write", stat_rdata, 8'h04);

        // R10 / R11
        clash_evt = 1; tick();
        check("R10 clash sets", stat_rdata, 8'h05);
        irq_en = 8'h01; #1;
        check("R11 irq enabled", irq, 1);
        irq_en = 8'h02; #1;
        check("R11 irq masked", irq, 0);
        irq_en = 8'h00;

        // R4 set beats clear
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 8'hFE; clash_evt = 1; tick();
        check("R4 set wins", stat_rdata, 8'h05);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 8'hFE; tick();
        check("R3 clash cleared", stat_rdata, 8'h04);

        // R5 receive
        rx_offer = 1; #1;
        check("R5 store accepted", rx_store, 1);
        tick();
        check("R5 full sets", stat_rdata, 8'h06);
        rdata_rd = 1; tick();
        check("R5 read clears full", stat_rdata, 8'h04);

        // R6 / R7 overrun
        rx_offer = 1; tick();
        rx_offer = 1; #1;
        check("R6 no store on overrun", rx_store, 0);
        tick();
        check("R6 overrun sets, full kept", stat_rdata, 8'h46);
        check("R7 halt high", halt, 1);
        rdata_rd = 1; tick();
        check("R5 full cleared", stat_rdata, 8'h44);
        rx_offer = 1; #1;
        check("R7 no store while halted", rx_store, 0);
        tick();
        check("R7 halted offer ignored", stat_rdata, 8'h44);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata = 8'hBF; tick();
        check("R3 overrun cleared", stat_rdata, 8'h04);
        check("R7 halt released", halt, 0);

        // R8 enable low
        tdata_wr = 1; tick();
        check("R8 empty cleared", stat_rdata, 8'h00);
        tx_en = 0; tick();
        check("R8 disabled sets empty", stat_rdata, 8'h04);
        tdata_wr = 1; tick();
        check("R8 write while disabled keeps empty", stat_rdata, 8'h04);
        tx_en = 1;

        // R9 auto clear
        tx_last_evt = 1; tick();
        check("R9 done set again", stat_rdata, 8'h0C);
        tdata_wr = 1; tick();
        check("R9 data write clears done", stat_rdata, 8'h00);
        irq_en = 8'hFF; #1;
        check("R11 no flags no irq", irq, 0);

        tick();
        tick();
        finish_run();
    end
endmodule